// File: doc/BRIEF.md
# Serial FIFO Trigger-Level Flag Controller

This block holds the transmit and receive byte queues of a UART-style serial port. It sits between a simple register bus on one side and the transmit and receive shift engines on the other. Software writes bytes into the transmit queue and reads bytes from the receive queue. The shift engines pop transmit bytes and push received bytes through plain strobe handshakes.

Two status flags tell software when to service the queues, each measured against a threshold chosen by a 2-bit field. The transmit request flag asks for more data once the transmit queue has drained to its threshold. The receive full flag asks for a read once enough bytes have arrived. Software clears a flag by reading it as 1 and then writing 0. If the condition behind the flag still holds, the flag stays set, so a service routine cannot drop a request it has not satisfied. Both occupancy counts are visible together in a single 16-bit count word.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: After reset both flags are 0, both queues are empty and `fifo_count` reads 0.
- R2: The transmit flag is set at the clock edge that ends any cycle in which the transmit occupancy is less than or equal to the transmit threshold. The threshold is selected by `tx_trig_sel`: 0 selects 8, 1 selects 4, 2 selects 2 and 3 selects 1.
- R3: The receive flag is set at the clock edge that ends any cycle in which the receive occupancy is greater than or equal to the receive threshold. The threshold is selected by `rx_trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R4: A flag goes to 0 only after software has seen it as 1 and then writes 0 to it. Seeing it means a cycle with `status_rd` high while the flag reads 1. Writing 0 means a cycle with `flag_wr` high and that flag's write bit at 0. The write consumes the earlier read. A 0 written without such a read, or a 1 written, leaves the flag unchanged.
- R5: A clear written in a cycle where the flag's condition still holds leaves the flag at 1.
- R6: `fifo_count[15:8]` holds the transmit occupancy and `fifo_count[7:0]` holds the receive occupancy. Both change on the same clock edge as the accepted push or pop.
- R7: A bus write (`tx_wr`) while the transmit queue holds 16 bytes is ignored.
- R8: A bus read (`rx_rd`) while the receive queue is empty is ignored and leaves the count unchanged.
- R9: A receive engine push while the receive queue holds 16 bytes is ignored.
- R10: Both queues are first-in first-out. `tx_data` shows the oldest transmit byte and `rx_rdata` shows the oldest receive byte.
- R11: An accepted push and an accepted pop in the same cycle leave that queue's occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Bus write of one byte into the transmit queue |
| tx_wdata | input | 8 | Byte written by the bus |
| rx_rd | input | 1 | Bus read that removes the oldest receive byte |
| rx_rdata | output | 8 | Oldest receive byte |
| tx_trig_sel | input | 2 | Transmit threshold select |
| rx_trig_sel | input | 2 | Receive threshold select |
| status_rd | input | 1 | Bus read of the status flags; arms each flag that reads 1 |
| flag_wr | input | 1 | Bus write of the status flags |
| flag_wdata_tx | input | 1 | Value written to the transmit flag |
| flag_wdata_rx | input | 1 | Value written to the receive flag |
| tx_req_flag | output | 1 | Transmit request flag |
| rx_full_flag | output | 1 | Receive full flag |
| fifo_count | output | 16 | Transmit occupancy in [15:8], receive occupancy in [7:0] |
| tx_pop | input | 1 | Transmit engine takes the oldest byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue holds no byte |
| rx_push | input | 1 | Receive engine delivers a byte |
| rx_data | input | 8 | Byte delivered by the receive engine |
| rx_full | output | 1 | Receive queue holds 16 bytes |

## Verification
For every threshold code, each queue is walked from empty to full and back again one byte at a time. At every level a status read and a clear are attempted. This separates a "below" comparison from an "at or below" comparison, and it shows whether a clear is honoured exactly at the levels where the condition has lapsed. The overfill and overdrain steps at the ends expose counts that wrap or move on ignored accesses. Separate sequences apply clears with no prior read, writes of 1, and simultaneous push and pop on both queues. These tell an unarmed clear and a same-cycle count update apart from a correct one.

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  input  logic         rx_rd,
  output logic [W-1:0] rx_rdata,
  input  logic [1:0]   tx_trig_sel,
  input  logic [1:0]   rx_trig_sel,
  input  logic         status_rd,
  input  logic         flag_wr,
  input  logic         flag_wdata_tx,
  input  logic         flag_wdata_rx,
  output logic         tx_req_flag,
  output logic         rx_full_flag,
  output logic [15:0]  fifo_count,
  input  logic         tx_pop,
  output logic [W-1:0] tx_data,
  output logic         tx_empty,
  input  logic         rx_push,
  input  logic [W-1:0] rx_data,
  output logic         rx_full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic          tx_arm, rx_arm;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire tx_in  = tx_wr   && (tx_cnt != CW'(DEPTH));
  wire tx_out = tx_pop  && (tx_cnt != '0);
  wire rx_in  = rx_push && (rx_cnt != CW'(DEPTH));
  wire rx_out = rx_rd   && (rx_cnt != '0);

  always_comb begin
    case (tx_trig_sel)
      2'd0:    tx_thr = CW'(DEPTH / 2);
      2'd1:    tx_thr = CW'(DEPTH / 4);
      2'd2:    tx_thr = CW'(DEPTH / 8);
      default: tx_thr = CW'(DEPTH / 16);
    endcase
    case (rx_trig_sel)
      2'd0:    rx_thr = CW'(1);
      2'd1:    rx_thr = CW'(DEPTH / 4);
      2'd2:    rx_thr = CW'(DEPTH / 2);
      default: rx_thr = CW'(DEPTH - 2);
    endcase
  end

  wire tx_cond = tx_cnt <= tx_thr;
  wire rx_cond = rx_cnt >= rx_thr;
  wire tx_try  = flag_wr && !flag_wdata_tx;
  wire rx_try  = flag_wr && !flag_wdata_rx;

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= tx_wdata;
    if (rx_in) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= nxt(tx_wp);
      if (tx_out) tx_rp <= nxt(tx_rp);
      if (rx_in)  rx_wp <= nxt(rx_wp);
      if (rx_out) rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_req_flag <= 1'b0; rx_full_flag <= 1'b0;
      tx_arm <= 1'b0;      rx_arm <= 1'b0;
    end else begin
      tx_req_flag  <= tx_cond || (tx_req_flag && !(tx_try && tx_arm));
      rx_full_flag <= rx_cond || (rx_full_flag && !(rx_try && rx_arm));
      tx_arm <= (status_rd && tx_req_flag) || (tx_arm && !tx_try);
      rx_arm <= (status_rd && rx_full_flag) || (rx_arm && !rx_try);
    end
  end

  assign fifo_count = {8'(tx_cnt), 8'(rx_cnt)};
  assign tx_data    = tx_mem[tx_rp];
  assign rx_rdata   = rx_mem[rx_rp];
  assign tx_empty   = tx_cnt == '0;
  assign rx_full    = rx_cnt == CW'(DEPTH);
endmodule

module sfifo_trig_ctrl_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_wr,
  input logic        rx_rd,
  input logic        tx_pop,
  input logic        rx_push,
  input logic [1:0]  tx_trig_sel,
  input logic [1:0]  rx_trig_sel,
  input logic        flag_wr,
  input logic        flag_wdata_tx,
  input logic        flag_wdata_rx,
  input logic        tx_req_flag,
  input logic        rx_full_flag,
  input logic [15:0] fifo_count
);
  function automatic int tlim(input logic [1:0] s);
    return DEPTH >> (s + 1);
  endfunction
  function automatic int rlim(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? DEPTH / 4 : (s == 2'd2) ? DEPTH / 2 : DEPTH - 2;
  endfunction

  wire [7:0] tc = fifo_count[15:8];
  wire [7:0] rc = fifo_count[7:0];

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tc) <= DEPTH) && (int'(rc) <= DEPTH));
  p_tx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tc) <= tlim(tx_trig_sel)) |=> tx_req_flag);
  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rc) >= rlim(rx_trig_sel)) |=> rx_full_flag);
  p_tx_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req_flag) |-> $past(flag_wr && !flag_wdata_tx));
  p_rx_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_flag) |-> $past(flag_wr && !flag_wdata_rx));
  p_full_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tc) == DEPTH && tx_wr && !tx_pop) |=> $stable(tc));
  p_empty_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == 8'd0 && rx_rd && !rx_push) |=> $stable(rc));
  p_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rc) == DEPTH && rx_push && !rx_rd) |=> $stable(rc));
endmodule

bind sfifo_trig_ctrl sfifo_trig_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .rx_rd(rx_rd), .tx_pop(tx_pop),
  .rx_push(rx_push), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
  .flag_wr(flag_wr), .flag_wdata_tx(flag_wdata_tx), .flag_wdata_rx(flag_wdata_rx),
  .tx_req_flag(tx_req_flag), .rx_full_flag(rx_full_flag), .fifo_count(fifo_count)
);

// File: tb/sfifo_trig_ctrl_test.sv
module sfifo_trig_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_wr = 0, rx_rd = 0, status_rd = 0, flag_wr = 0, fw_tx = 0, fw_rx = 0;
  logic tx_pop = 0, rx_push = 0;
  logic [7:0] tx_wdata = 0, rx_data = 0;
  logic [1:0] tsel = 0, rsel = 0;
  logic [7:0] rx_rdata, tx_data;
  logic tx_req_flag, rx_full_flag, tx_empty, rx_full;
  logic [15:0] fifo_count;

  int vectors = 0, errors = 0;
  bit done = 0;
  string req = "R1";
  logic [7:0] tq[$], rq[$];
  bit mtf = 0, mrf = 0, mta = 0, mra = 0;

  always #4 clk = ~clk;

  sfifo_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .tx_trig_sel(tsel), .rx_trig_sel(rsel), .status_rd(status_rd),
    .flag_wr(flag_wr), .flag_wdata_tx(fw_tx), .flag_wdata_rx(fw_rx),
    .tx_req_flag(tx_req_flag), .rx_full_flag(rx_full_flag), .fifo_count(fifo_count),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .rx_push(rx_push),
    .rx_data(rx_data), .rx_full(rx_full)
  );

  function automatic int tthr(input logic [1:0] s);
    return 8 >> s;
  endfunction
  function automatic int rthr(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("fifo_count", fifo_count, {8'(tq.size()), 8'(rq.size())});
    chk("tx_req_flag (R2)", 16'(tx_req_flag), 16'(mtf));
    chk("rx_full_flag (R3)", 16'(rx_full_flag), 16'(mrf));
    chk("tx_empty", 16'(tx_empty), 16'(tq.size() == 0));
    chk("rx_full", 16'(rx_full), 16'(rq.size() == 16));
    if (tq.size() > 0) chk("tx_data (R10)", 16'(tx_data), 16'(tq[0]));
    if (rq.size() > 0) chk("rx_rdata (R10)", 16'(rx_rdata), 16'(rq[0]));
  endtask

  task automatic model();
    bit tc, rc, tcl, rcl, ti, to, ri, ro;
    tc  = tq.size() <= tthr(tsel);
    rc  = rq.size() >= rthr(rsel);
    tcl = flag_wr && !fw_tx;
    rcl = flag_wr && !fw_rx;
    ti = tx_wr && tq.size() < 16;   to = tx_pop && tq.size() > 0;
    ri = rx_push && rq.size() < 16; ro = rx_rd && rq.size() > 0;
    begin
      bit ntf, nrf;
      ntf = tc || (mtf && !(tcl && mta));
      nrf = rc || (mrf && !(rcl && mra));
      mta = (status_rd && mtf) || (mta && !tcl);
      mra = (status_rd && mrf) || (mra && !rcl);
      mtf = ntf; mrf = nrf;
    end
    if (to) void'(tq.pop_front());
    if (ti) tq.push_back(tx_wdata);
    if (ro) void'(rq.pop_front());
    if (ri) rq.push_back(rx_data);
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    tx_wr = 0; rx_rd = 0; status_rd = 0; flag_wr = 0; fw_tx = 0; fw_rx = 0;
    tx_pop = 0; rx_push = 0;
    compare();
  endtask

  task automatic read_and_clear();
    status_rd = 1; step();
    flag_wr = 1; fw_tx = 0; fw_rx = 0; step();
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1";
    compare();

    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      req = "R2/R5/R6/R7";
      read_and_clear();
      for (int i = 0; i < 17; i++) begin
        tx_wr = 1; tx_wdata = 8'(s * 40 + i * 3 + 1); step();
        read_and_clear();
      end
      req = "R2/R10";
      for (int i = 0; i < 17; i++) begin
        tx_pop = 1; step();
        read_and_clear();
      end
    end

    for (int s = 0; s < 4; s++) begin
      rsel = 2'(s);
      req = "R3/R5/R6/R9";
      for (int i = 0; i < 17; i++) begin
        rx_push = 1; rx_data = 8'(s * 50 + i * 7 + 2); step();
        read_and_clear();
      end
      req = "R3/R8/R10";
      for (int i = 0; i < 17; i++) begin
        rx_rd = 1; step();
        read_and_clear();
      end
    end

    // R4: unarmed clear and write of 1 leave the flags set
    req = "R4";
    tsel = 2'd3; rsel = 2'd0;
    for (int i = 0; i < 3; i++) begin tx_wr = 1; tx_wdata = 8'(200 + i); step(); end
    rx_push = 1; rx_data = 8'h5a; step();
    rx_rd = 1; step();
    flag_wr = 1; fw_tx = 0; fw_rx = 0; step();
    status_rd = 1; step();
    flag_wr = 1; fw_tx = 1; fw_rx = 1; step();
    flag_wr = 1; fw_tx = 0; fw_rx = 1; step();
    flag_wr = 1; fw_tx = 0; fw_rx = 0; step();
    flag_wr = 1; fw_tx = 0; fw_rx = 0; step();

    // R11: simultaneous accepted push and pop
    req = "R11";
    for (int i = 0; i < 2; i++) begin rx_push = 1; rx_data = 8'(90 + i); step(); end
    for (int i = 0; i < 4; i++) begin
      tx_wr = 1; tx_wdata = 8'(120 + i); tx_pop = 1;
      rx_push = 1; rx_data = 8'(140 + i); rx_rd = 1;
      step();
    end
    for (int i = 0; i < 4; i++) begin tx_pop = 1; rx_rd = 1; step(); end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule